// File: doc/BRIEF.md
# Lockable Translation Lookaside Buffer

This block is a fully associative translation cache with 32 entries. Each entry pairs a match part with a result part. The match part holds a virtual tag, a page size code, a valid flag and a preserved flag. The result part holds a physical frame and three memory attributes: byte order, element size and a mixed-size flag. Software never writes an entry directly. It fills a match staging register and a result staging register, then issues a load command. The load copies both staged words into the entry named by a replacement pointer.

The replacement pointer lives in a lock register together with a locked base count. Entries below the base sit in a locked region that loads never touch. After each load the pointer steps forward by one. Past the last entry it wraps back to the base.

A combinational lookup port takes a 32-bit virtual address. Each entry compares at its own page size, so 4 KB, 64 KB, 1 MB and 16 MB mappings can coexist. The port returns hit, the index of the winning entry, the translated address and the attributes. Two invalidation commands are provided:
- A targeted flush removes the entry whose tag and size match the match staging word.
- A global flush clears every entry that is not preserved.

The register port is plain control: a write takes effect at the clock edge where the write enable is high. Read data appears on the edge that follows a read enable and holds until the next read. The port accepts every access, so there is no back-pressure.

Top module: `lockable_tlb`

## Requirements
- R1: After reset every entry is invalid, both staging registers and the lock register read 0, and every lookup misses.
- R2: Register word 0 is the match staging register. Bits 31:12 hold the virtual tag, bit 3 the preserved flag, bit 2 the valid flag and bits 1:0 the size code. All other bits read 0.
- R3: Register word 1 is the result staging register. Bits 31:12 hold the physical frame, bit 9 byte order, bits 8:7 element size (0=8, 1=16, 2=32, 3=64 bits) and bit 6 the mixed-size flag. All other bits read 0.
- R4: Register word 2 is the lock register, with the pointer in bits 4:0 and the locked base in bits 12:8. A pointer written below the base is stored as the base.
- R5: The replacement pointer always lies between the locked base and 31 inclusive.
- R6: A write of 1 in bit 0 to register word 3 copies both staging words into the entry at the pointer. The pointer then advances by one and wraps to the base after entry 31.
- R7: A valid entry matches when the tag bits above its page offset equal the lookup address. Size code 0 is 1 MB and compares VA[31:20]; code 1 is 64 KB and compares VA[31:16]; code 2 is 4 KB and compares VA[31:12]; code 3 is 16 MB and compares VA[31:24]. Staged tag bits below the page boundary are ignored.
- R8: On a hit, the translated address takes the frame bits above the page offset from the entry and the offset bits from the lookup address. The outputs also carry the entry's byte order, element size and mixed flag.
- R9: On a miss, hit, index, address and attributes are all 0. An entry loaded with its valid flag clear never hits.
- R10: When several valid entries match, the lowest index wins.
- R11: A write of 1 in bit 0 to register word 4 invalidates every entry whose size equals the staged size and whose tag matches the staged tag at that size, preserved or not. Entries of another size are untouched.
- R12: A write of 1 in bit 0 to register word 5 invalidates every entry whose preserved flag is clear and keeps preserved entries valid.
- R13: Entries below the locked base keep their contents across any number of loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the read strobe |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_index | output | 5 | Index of the winning entry |
| lk_pa | output | 32 | Translated physical address |
| lk_big_endian | output | 1 | Byte order attribute of the hit |
| lk_elem_size | output | 2 | Element size attribute of the hit |
| lk_mixed | output | 1 | Mixed-size attribute of the hit |

## Verification
The embedded assertions check three things on every cycle:
- The pointer stays inside its window and steps correctly after each load.
- A targeted flush always clears its matching entry, and a global flush spares exactly the preserved ones.
- A reported hit belongs to a matching entry with no lower-index match, and a miss drives the result to zero.

Other properties need the bench's scenarios:
- Register field placement and the stored value of an out-of-range pointer.
- Per-size address composition and the ignoring of staged tag bits below the page boundary.
- Survival of the locked region across a pointer wrap.
- The interplay of preserved entries with both flush kinds.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    PG_1M  = 2'd0,
    PG_64K = 2'd1,
    PG_4K  = 2'd2,
    PG_16M = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic [19:0] tag;
    logic        pres;
    logic        valid;
    pg_size_e    size;
  } cam_t;

  typedef struct packed {
    logic [19:0] pfn;
    logic        big_end;
    logic [1:0]  esz;
    logic        mixed;
  } ram_t;

  localparam logic [2:0] RA_CAM   = 3'd0;
  localparam logic [2:0] RA_RAM   = 3'd1;
  localparam logic [2:0] RA_LOCK  = 3'd2;
  localparam logic [2:0] RA_LOAD  = 3'd3;
  localparam logic [2:0] RA_FLONE = 3'd4;
  localparam logic [2:0] RA_FLALL = 3'd5;

  localparam int LOCK_BASE_LSB = 8;

  // Mask over VA[31:12] of the bits that belong to the page frame.
  function automatic logic [19:0] frame_mask(input pg_size_e s);
    case (s)
      PG_4K:   frame_mask = 20'hFFFFF;
      PG_64K:  frame_mask = 20'hFFFF0;
      PG_1M:   frame_mask = 20'hFFF00;
      default: frame_mask = 20'hFF000;
    endcase
  endfunction

endpackage

// File: rtl/tlb_ctrl_regs.sv
module tlb_ctrl_regs
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output cam_t             stage_cam,
  output ram_t             stage_ram,
  output logic [IDX_W-1:0] victim,
  output logic             cmd_load,
  output logic             cmd_flush_one,
  output logic             cmd_flush_all
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  logic [IDX_W-1:0] base_q;
  logic [IDX_W-1:0] base_in, vic_raw, vic_in;
  logic [IDX_W-1:0] vic_next;
  logic             lock_wr;
  logic [31:0]      lock_word, cam_word, ram_word;
  logic             unused_wdata;

  assign unused_wdata = ^wdata;

  assign lock_wr       = wr_en && (addr == RA_LOCK);
  assign cmd_load      = wr_en && (addr == RA_LOAD)  && wdata[0];
  assign cmd_flush_one = wr_en && (addr == RA_FLONE) && wdata[0];
  assign cmd_flush_all = wr_en && (addr == RA_FLALL) && wdata[0];

  // Clamp the written fields into the legal window.
  always_comb begin
    base_in = wdata[LOCK_BASE_LSB +: IDX_W];
    if (base_in > LAST) base_in = LAST;
    vic_raw = wdata[0 +: IDX_W];
    if (vic_raw > LAST) vic_raw = LAST;
    vic_in = (vic_raw < base_in) ? base_in : vic_raw;
  end

  assign vic_next = (victim == LAST) ? base_q : victim + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_cam <= '0;
      stage_ram <= '0;
      base_q    <= '0;
      victim    <= '0;
    end else begin
      if (wr_en && addr == RA_CAM) begin
        stage_cam.tag   <= wdata[31:12];
        stage_cam.pres  <= wdata[3];
        stage_cam.valid <= wdata[2];
        stage_cam.size  <= pg_size_e'(wdata[1:0]);
      end
      if (wr_en && addr == RA_RAM) begin
        stage_ram.pfn     <= wdata[31:12];
        stage_ram.big_end <= wdata[9];
        stage_ram.esz     <= wdata[8:7];
        stage_ram.mixed   <= wdata[6];
      end
      if (lock_wr) begin
        base_q <= base_in;
        victim <= vic_in;
      end else if (cmd_load) begin
        victim <= vic_next;
      end
    end
  end

  always_comb begin
    lock_word = '0;
    lock_word[LOCK_BASE_LSB +: IDX_W] = base_q;
    lock_word[0 +: IDX_W]             = victim;
    cam_word = {stage_cam.tag, 8'h00, stage_cam.pres, stage_cam.valid,
                stage_cam.size};
    ram_word = {stage_ram.pfn, 2'b00, stage_ram.big_end, stage_ram.esz,
                stage_ram.mixed, 6'b000000};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        RA_CAM:  rdata <= cam_word;
        RA_RAM:  rdata <= ram_word;
        RA_LOCK: rdata <= lock_word;
        default: rdata <= '0;
      endcase
    end
  end

  p_victim_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (victim >= base_q) && (victim <= LAST));

  p_victim_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |=> victim == (($past(victim) == LAST) ? $past(base_q)
                                                    : $past(victim) + 1'b1));

  p_base_steady_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_wr |=> $stable(base_q));

endmodule

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int MY_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cam_t             stage_cam,
  input  ram_t             stage_ram,
  input  logic [IDX_W-1:0] victim,
  input  logic             cmd_load,
  input  logic             cmd_flush_one,
  input  logic             cmd_flush_all,
  input  logic [19:0]      lk_vpn,
  output logic             match,
  output ram_t             ram_q,
  output pg_size_e         size_q
);

  cam_t cam_q;
  logic sel;
  logic flush_hit;

  assign sel = cmd_load && (victim == IDX_W'(MY_IDX));

  // Targeted flush compares at the staged size; preserved flag ignored.
  assign flush_hit = (cam_q.size == stage_cam.size) &&
                     (((cam_q.tag ^ stage_cam.tag) &
                       frame_mask(stage_cam.size)) == 20'h0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cam_q <= '0;
      ram_q <= '0;
    end else if (sel) begin
      cam_q <= stage_cam;
      ram_q <= stage_ram;
    end else if (cmd_flush_one && flush_hit) begin
      cam_q.valid <= 1'b0;
    end else if (cmd_flush_all && !cam_q.pres) begin
      cam_q.valid <= 1'b0;
    end
  end

  assign match  = cam_q.valid &&
                  (((cam_q.tag ^ lk_vpn) & frame_mask(cam_q.size)) == 20'h0);
  assign size_q = cam_q.size;

  p_flush_one_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_flush_one && flush_hit) |=> !cam_q.valid);

  p_flush_all_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_flush_all && cam_q.pres && cam_q.valid) |=> cam_q.valid);

  p_flush_all_drops_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_flush_all && !cam_q.pres) |=> !cam_q.valid);

  p_unselected_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel) |=> $stable(ram_q));

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_ENTRIES-1:0]     match,
  input  ram_t [N_ENTRIES-1:0]     rams,
  input  pg_size_e [N_ENTRIES-1:0] sizes,
  input  logic [31:0]              va,
  output logic                     hit,
  output logic [IDX_W-1:0]         idx,
  output logic [31:0]              pa,
  output logic                     big_end,
  output logic [1:0]               esz,
  output logic                     mixed
);

  ram_t        win_ram;
  pg_size_e    win_size;
  logic [19:0] fm;

  // Lowest index wins: scan from the top so the last assignment is lowest.
  always_comb begin
    hit      = 1'b0;
    idx      = '0;
    win_ram  = '0;
    win_size = PG_1M;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit      = 1'b1;
        idx      = IDX_W'(i);
        win_ram  = rams[i];
        win_size = sizes[i];
      end
    end
  end

  assign fm = frame_mask(win_size);

  always_comb begin
    if (hit) begin
      pa      = {(win_ram.pfn & fm) | (va[31:12] & ~fm), va[11:0]};
      big_end = win_ram.big_end;
      esz     = win_ram.esz;
      mixed   = win_ram.mixed;
    end else begin
      pa      = '0;
      big_end = 1'b0;
      esz     = 2'b00;
      mixed   = 1'b0;
    end
  end

  p_hit_is_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match[idx]);

  p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match == '0) |-> (pa == 32'h0 && idx == '0 && !hit));

  p_lowest_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((match & ((N_ENTRIES'(1) << idx) - N_ENTRIES'(1))) == '0));

  p_offset_passes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (pa[11:0] == va[11:0]));

endmodule

// File: rtl/lockable_tlb.sv
module lockable_tlb
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_rd_en,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [31:0]      lk_va,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_index,
  output logic [31:0]      lk_pa,
  output logic             lk_big_endian,
  output logic [1:0]       lk_elem_size,
  output logic             lk_mixed
);

  cam_t             stage_cam;
  ram_t             stage_ram;
  logic [IDX_W-1:0] victim;
  logic             cmd_load, cmd_flush_one, cmd_flush_all;

  logic [N_ENTRIES-1:0]     match;
  ram_t [N_ENTRIES-1:0]     rams;
  pg_size_e [N_ENTRIES-1:0] sizes;

  tlb_ctrl_regs #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) regs_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (reg_wr_en),
    .rd_en         (reg_rd_en),
    .addr          (reg_addr),
    .wdata         (reg_wdata),
    .rdata         (reg_rdata),
    .stage_cam     (stage_cam),
    .stage_ram     (stage_ram),
    .victim        (victim),
    .cmd_load      (cmd_load),
    .cmd_flush_one (cmd_flush_one),
    .cmd_flush_all (cmd_flush_all)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    tlb_entry #(.IDX_W(IDX_W), .MY_IDX(g)) ent_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .stage_cam     (stage_cam),
      .stage_ram     (stage_ram),
      .victim        (victim),
      .cmd_load      (cmd_load),
      .cmd_flush_one (cmd_flush_one),
      .cmd_flush_all (cmd_flush_all),
      .lk_vpn        (lk_va[31:12]),
      .match         (match[g]),
      .ram_q         (rams[g]),
      .size_q        (sizes[g])
    );
  end

  tlb_pick #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) pick_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .match   (match),
    .rams    (rams),
    .sizes   (sizes),
    .va      (lk_va),
    .hit     (lk_hit),
    .idx     (lk_index),
    .pa      (lk_pa),
    .big_end (lk_big_endian),
    .esz     (lk_elem_size),
    .mixed   (lk_mixed)
  );

  p_one_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd_load, cmd_flush_one, cmd_flush_all}) <= 1);

endmodule

// File: tb/lockable_tlb_tb_top.sv
module lockable_tlb_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] lk_va = '0;
  logic        lk_hit;
  logic [4:0]  lk_index;
  logic [31:0] lk_pa;
  logic        lk_big_endian;
  logic [1:0]  lk_elem_size;
  logic        lk_mixed;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lockable_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_va(lk_va), .lk_hit(lk_hit), .lk_index(lk_index), .lk_pa(lk_pa),
    .lk_big_endian(lk_big_endian), .lk_elem_size(lk_elem_size),
    .lk_mixed(lk_mixed)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd_en = 1'b1;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  // attr packs {byte order, element size, mixed}
  task automatic look(input string req, input logic [31:0] va,
                      input logic hit, input logic [4:0] idx,
                      input logic [31:0] pa, input logic [3:0] attr);
    @(negedge clk);
    lk_va = va;
    #2;
    chk(req, {lk_hit, lk_index, lk_big_endian, lk_elem_size, lk_mixed},
        hit ? {1'b1, idx, attr} : 32'h0);
    chk(req, lk_pa, hit ? pa : 32'h0);
  endtask

  function automatic logic [31:0] pmask(input int c);
    case (c)
      0: pmask = 32'hFFF0_0000;
      1: pmask = 32'hFFFF_0000;
      2: pmask = 32'hFFFF_F000;
      default: pmask = 32'hFF00_0000;
    endcase
  endfunction

  function automatic logic [31:0] ramw(input logic [31:0] pa,
                                       input logic [3:0] attr);
    ramw = (pa & 32'hFFFF_F000) | (32'(attr) << 6);
  endfunction

  function automatic logic [3:0] attr_of(input int i);
    attr_of = {i[0], i[2:1], i[3]};
  endfunction

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, d); chk("R1 cam", d, 0);
    rd(3'd1, d); chk("R1 ram", d, 0);
    rd(3'd2, d); chk("R1 lock", d, 0);
    look("R1 miss", 32'h0000_0123, 0, 0, 0, 0);

    // R2 / R3 field layout
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); chk("R2 layout", d, 32'hFFFF_F00F);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, d); chk("R3 layout", d, 32'hFFFF_F3C0);
    // R4 pointer below base is lifted to base
    wr(3'd2, (4 << 8) | 2);  rd(3'd2, d); chk("R4 clamp", d, 32'h404);
    wr(3'd2, (4 << 8) | 31); rd(3'd2, d); chk("R4 layout", d, 32'h41F);

    // R6 sweep: fill all 32 entries with 4KB pages
    wr(3'd2, 0);
    for (int i = 0; i < 32; i++) begin
      wr(3'd0, ((32'h10000 + i) << 12) | 32'h4 | 32'h2);
      wr(3'd1, ramw((32'h80000 + i) << 12, attr_of(i)));
      wr(3'd3, 1);
      rd(3'd2, d);
      chk("R6 advance", d, (i + 1) % 32);
    end
    for (int i = 0; i < 32; i++) begin
      logic [31:0] off;
      off = (i * 37) & 32'hFFF;
      look("R6 R8 fill", ((32'h10000 + i) << 12) | off, 1, 5'(i),
           ((32'h80000 + i) << 12) | off, attr_of(i));
    end

    // R13 / R5 locked region with wrap
    wr(3'd2, (8 << 8) | 31); rd(3'd2, d); chk("R4 base", d, 32'h81F);
    wr(3'd0, (32'h20000 << 12) | 6); wr(3'd1, ramw(32'hA000_0000, 0));
    wr(3'd3, 1); rd(3'd2, d); chk("R6 wrap to base", d, 32'h808);
    wr(3'd0, (32'h20001 << 12) | 6); wr(3'd1, ramw(32'hA000_1000, 0));
    wr(3'd3, 1); rd(3'd2, d); chk("R5 window", d, 32'h809);
    look("R13 replaced", 32'h1000_8000, 0, 0, 0, 0);
    look("R6 new8", 32'h2000_1010, 1, 8, 32'hA000_1010, 0);
    look("R6 new31", 32'h2000_0010, 1, 31, 32'hA000_0010, 0);
    for (int j = 0; j < 8; j++)
      look("R13 locked kept", ((32'h10000 + j) << 12) | 32'h44, 1, 5'(j),
           ((32'h80000 + j) << 12) | 32'h44, attr_of(j));

    // R12 global flush with one preserved entry
    wr(3'd2, 3);
    wr(3'd0, (32'h10003 << 12) | 32'h8 | 32'h4 | 32'h2);
    wr(3'd1, ramw(32'h8000_3000, attr_of(3)));
    wr(3'd3, 1);
    wr(3'd5, 1);
    look("R12 preserved", 32'h1000_3ABC, 1, 3, 32'h8000_3ABC, attr_of(3));
    look("R12 cleared", 32'h1000_5ABC, 0, 0, 0, 0);
    look("R12 cleared2", 32'h2000_1000, 0, 0, 0, 0);

    // R11 targeted flush: wrong size untouched, right size clears preserved
    wr(3'd0, (32'h10003 << 12) | 1); wr(3'd4, 1);
    look("R11 other size", 32'h1000_3001, 1, 3, 32'h8000_3001, attr_of(3));
    wr(3'd0, (32'h10003 << 12) | 2); wr(3'd4, 1);
    look("R11 flushed", 32'h1000_3001, 0, 0, 0, 0);

    // R7 / R8 page size sweep
    wr(3'd2, 0);
    for (int c = 0; c < 4; c++) begin
      logic [31:0] vb, pb, pm;
      vb = ((32'h40 + 32'h10 * c) << 24) | 32'h00A5_A000;
      pb = ((32'h90 + c) << 24) | 32'h00C3_D000;
      pm = pmask(c);
      wr(3'd0, vb | 32'h4 | 32'(c));
      wr(3'd1, ramw(pb, {c[0], 2'(c), c[1]}));
      wr(3'd3, 1);
      for (int k = 0; k < 8; k++) begin
        logic [31:0] off;
        off = (32'h0013_579B * (k + 1)) & ~pm;
        look("R7 R8 size", (vb & pm) | off, 1, 5'(c), (pb & pm) | off,
             {c[0], 2'(c), c[1]});
      end
      look("R7 boundary", (vb & pm) ^ (pm & ~(pm << 1)), 0, 0, 0, 0);
    end

    // R9 entry loaded invalid
    wr(3'd0, (32'h80000 << 12) | 2); wr(3'd3, 1);
    look("R9 invalid", 32'h8000_0123, 0, 0, 0, 0);

    // R10 overlap: 16MB at idx5 and 4KB at idx6
    wr(3'd0, 32'hC000_0000 | 4 | 3); wr(3'd1, ramw(32'hD100_0000, 0));
    wr(3'd3, 1);
    wr(3'd0, 32'hC000_1000 | 4 | 2); wr(3'd1, ramw(32'hE234_5000, 4'b1000));
    wr(3'd3, 1);
    look("R10 lowest", 32'hC000_1234, 1, 5, 32'hD100_1234, 0);
    look("R10 single", 32'hC000_2234, 1, 5, 32'hD100_2234, 0);
    wr(3'd0, 32'hC000_0000 | 3); wr(3'd4, 1);
    look("R10 R11 next", 32'hC000_1234, 1, 6, 32'hE234_5234, 4'b1000);
    look("R11 16M gone", 32'hC000_2234, 0, 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule